// File: doc/BRIEF.md
# Processor Current-Mode Control Register

This block keeps the current operating mode of a processor core in one 10-bit register: the privilege level, the global interrupt enable, the two address translation mode bits, the memory access types used for instruction fetch and for data access while direct translation is active, and the watchpoint enable. It is read as a 32-bit control register value and also drives each field as a separate decoded output for the rest of the core.

Four events change the register. A software control-register write merges new data under a per-bit mask. Exception entry moves the core to the most privileged level and turns watchpoints off. Machine-error entry does the same and also forces both memory access types to strongly-ordered uncached. Exception return restores saved fields, taking them from the machine-error saved context, the refill saved context or the ordinary saved context, in that order of priority according to two flags. The saved contexts arrive on plain input ports. All pins are plain control and status signals; the block has no data stream and so no valid/ready handshake. Every update takes effect on the next rising clock edge.

Top module: `mode_ctrl_reg`

## Requirements
- R1: After reset (rst_n low, active-low asynchronous) the register holds privilege 0, interrupt enable 0, direct translation 1, paged translation 0, both access types 0 and watchpoint enable 0, so csr_rdata reads 32'h0000_0008.
- R2: csr_rdata carries the fields at fixed positions: privilege in bits 1:0, interrupt enable in bit 2, direct translation in bit 3, paged translation in bit 4, fetch access type in bits 6:5, data access type in bits 8:7, watchpoint enable in bit 9; bits 31:10 read as zero, and each decoded output equals its field.
- R3: With csr_we high and no event, each register bit whose csr_wmask bit is 1 takes the csr_wdata bit and every other bit keeps its value, visible one cycle later; mask bits 31:10 have no effect.
- R4: On exc_enter, privilege becomes 0 and watchpoint enable becomes 0 while interrupt enable, both translation bits and both access types keep their values.
- R5: On merr_enter, privilege and watchpoint enable become 0 and both access types become 2'b00 (strongly-ordered uncached); interrupt enable and the translation bits keep their values.
- R6: On exc_return with merr_flag high, privilege, watchpoint enable, fetch access type and data access type are loaded from the machine-error saved context.
- R7: On exc_return with merr_flag low and refill_flag high, privilege and watchpoint enable are loaded from the refill saved context and all other fields keep their values.
- R8: On exc_return with both flags low, privilege and watchpoint enable are loaded from the ordinary saved context and all other fields keep their values.
- R9: A csr_we in the same cycle as any entry or return event is discarded entirely; only the event's update applies. If an entry and a return coincide the entry wins.
- R10: With csr_we low and no event, the register holds its value whatever csr_wdata, csr_wmask and the saved-context ports carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_we | input | 1 | Software write strobe |
| csr_wmask | input | 32 | Per-bit write mask |
| csr_wdata | input | 32 | Write data |
| exc_enter | input | 1 | Ordinary exception entry |
| merr_enter | input | 1 | Machine-error exception entry |
| exc_return | input | 1 | Return from exception handler |
| merr_flag | input | 1 | Machine-error context is active |
| merr_ctx_priv | input | 2 | Saved privilege, machine-error context |
| merr_ctx_wpt | input | 1 | Saved watchpoint enable, machine-error context |
| merr_ctx_fmat | input | 2 | Saved fetch access type, machine-error context |
| merr_ctx_dmat | input | 2 | Saved data access type, machine-error context |
| refill_flag | input | 1 | Refill context is active |
| refill_ctx_priv | input | 2 | Saved privilege, refill context |
| refill_ctx_wpt | input | 1 | Saved watchpoint enable, refill context |
| norm_ctx_priv | input | 2 | Saved privilege, ordinary context |
| norm_ctx_wpt | input | 1 | Saved watchpoint enable, ordinary context |
| csr_rdata | output | 32 | Full register read value |
| priv_lvl | output | 2 | Current privilege level |
| int_en | output | 1 | Global interrupt enable |
| direct_xlat | output | 1 | Direct address translation on |
| paged_xlat | output | 1 | Paged address translation on |
| fetch_mat | output | 2 | Fetch access type in direct mode |
| data_mat | output | 2 | Load/store access type in direct mode |
| wpt_en | output | 1 | Watchpoint enable |

## Verification
Every result here is due exactly one rising edge after the cycle that presents the stimulus, because the only state is the register and all outputs are wired straight from it. The bench drives inputs on the falling edge, advances its own model of the register at the same time, waits for the next rising edge and compares every output one nanosecond later, before the next falling edge changes anything. Random cycles mix writes, both kinds of entry, returns with all flag combinations and idle cycles, and directed cycles pin down reset, write-versus-event collisions and the return priority.

// File: rtl/mode_ctrl_pkg.sv
package mode_ctrl_pkg;

  localparam int PRIV_W = 2;
  localparam int MAT_W  = 2;

  // Packed from bit 9 down to bit 0; the read value depends on this order.
  typedef struct packed {
    logic             wpt;
    logic [MAT_W-1:0] dmat;
    logic [MAT_W-1:0] fmat;
    logic             paged;
    logic             direct;
    logic             ie;
    logic [PRIV_W-1:0] priv;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam logic [MAT_W-1:0]  MAT_SUC   = 2'b00;
  localparam logic [MAT_W-1:0]  MAT_CC    = 2'b01;
  localparam logic [PRIV_W-1:0] PRIV_HIGH = '0;

  // Fields restored on exception return, after source selection.
  typedef struct packed {
    logic [PRIV_W-1:0] priv;
    logic              wpt;
    logic              load_mat;
    logic [MAT_W-1:0]  fmat;
    logic [MAT_W-1:0]  dmat;
  } restore_t;

endpackage

// File: rtl/mode_wr_merge.sv
module mode_wr_merge
  import mode_ctrl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  mode_t             cur,
  input  logic [XLEN-1:0]   wmask,
  input  logic [XLEN-1:0]   wdata,
  output mode_t             merged
);
  logic [MODE_W-1:0] cur_bits;
  logic [MODE_W-1:0] merged_bits;

  assign cur_bits = cur;

  // Only the implemented low bits take part; upper mask bits are dropped.
  for (genvar b = 0; b < MODE_W; b++) begin : g_bit
    assign merged_bits[b] = wmask[b] ? wdata[b] : cur_bits[b];
  end

  assign merged = mode_t'(merged_bits);

  logic unused_hi;
  if (XLEN > MODE_W) begin : g_unused
    assign unused_hi = ^{wmask[XLEN-1:MODE_W], wdata[XLEN-1:MODE_W]};
  end else begin : g_nounused
    assign unused_hi = 1'b0;
  end
endmodule

// File: rtl/mode_ctx_select.sv
module mode_ctx_select
  import mode_ctrl_pkg::*;
(
  input  logic              merr_flag,
  input  logic [PRIV_W-1:0] merr_priv,
  input  logic              merr_wpt,
  input  logic [MAT_W-1:0]  merr_fmat,
  input  logic [MAT_W-1:0]  merr_dmat,
  input  logic              refill_flag,
  input  logic [PRIV_W-1:0] refill_priv,
  input  logic              refill_wpt,
  input  logic [PRIV_W-1:0] norm_priv,
  input  logic              norm_wpt,
  output restore_t          rst_sel
);
  // Fixed priority: machine error, then refill, then ordinary context.
  always_comb begin
    rst_sel = '0;
    if (merr_flag) begin
      rst_sel.priv     = merr_priv;
      rst_sel.wpt      = merr_wpt;
      rst_sel.load_mat = 1'b1;
      rst_sel.fmat     = merr_fmat;
      rst_sel.dmat     = merr_dmat;
    end else if (refill_flag) begin
      rst_sel.priv = refill_priv;
      rst_sel.wpt  = refill_wpt;
    end else begin
      rst_sel.priv = norm_priv;
      rst_sel.wpt  = norm_wpt;
    end
  end
endmodule

// File: rtl/mode_next.sv
module mode_next
  import mode_ctrl_pkg::*;
(
  input  mode_t    cur,
  input  mode_t    wr_val,
  input  logic     wr_en,
  input  logic     enter,
  input  logic     merr_enter,
  input  logic     ret,
  input  restore_t rst_sel,
  output mode_t    nxt,
  output logic     load
);
  always_comb begin
    nxt  = cur;
    load = 1'b0;
    if (enter || merr_enter) begin
      load     = 1'b1;
      nxt.priv = PRIV_HIGH;
      nxt.wpt  = 1'b0;
      if (merr_enter) begin
        nxt.fmat = MAT_SUC;
        nxt.dmat = MAT_SUC;
      end
    end else if (ret) begin
      load     = 1'b1;
      nxt.priv = rst_sel.priv;
      nxt.wpt  = rst_sel.wpt;
      if (rst_sel.load_mat) begin
        nxt.fmat = rst_sel.fmat;
        nxt.dmat = rst_sel.dmat;
      end
    end else if (wr_en) begin
      load = 1'b1;
      nxt  = wr_val;
    end
  end
endmodule

// File: rtl/mode_ctrl_reg.sv
module mode_ctrl_reg
  import mode_ctrl_pkg::*;
#(
  parameter int   XLEN       = 32,
  parameter logic RST_DIRECT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [XLEN-1:0]   csr_wmask,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic              exc_enter,
  input  logic              merr_enter,
  input  logic              exc_return,
  input  logic              merr_flag,
  input  logic [1:0]        merr_ctx_priv,
  input  logic              merr_ctx_wpt,
  input  logic [1:0]        merr_ctx_fmat,
  input  logic [1:0]        merr_ctx_dmat,
  input  logic              refill_flag,
  input  logic [1:0]        refill_ctx_priv,
  input  logic              refill_ctx_wpt,
  input  logic [1:0]        norm_ctx_priv,
  input  logic              norm_ctx_wpt,
  output logic [XLEN-1:0]   csr_rdata,
  output logic [1:0]        priv_lvl,
  output logic              int_en,
  output logic              direct_xlat,
  output logic              paged_xlat,
  output logic [1:0]        fetch_mat,
  output logic [1:0]        data_mat,
  output logic              wpt_en
);
  localparam mode_t RST_VAL = '{wpt: 1'b0, dmat: MAT_SUC, fmat: MAT_SUC,
                                paged: 1'b0, direct: RST_DIRECT, ie: 1'b0,
                                priv: PRIV_HIGH};

  mode_t    mode_q, mode_d, wr_val;
  restore_t rst_sel;
  logic     load;

  mode_wr_merge #(.XLEN(XLEN)) u_merge (
    .cur    (mode_q),
    .wmask  (csr_wmask),
    .wdata  (csr_wdata),
    .merged (wr_val)
  );

  mode_ctx_select u_sel (
    .merr_flag   (merr_flag),
    .merr_priv   (merr_ctx_priv),
    .merr_wpt    (merr_ctx_wpt),
    .merr_fmat   (merr_ctx_fmat),
    .merr_dmat   (merr_ctx_dmat),
    .refill_flag (refill_flag),
    .refill_priv (refill_ctx_priv),
    .refill_wpt  (refill_ctx_wpt),
    .norm_priv   (norm_ctx_priv),
    .norm_wpt    (norm_ctx_wpt),
    .rst_sel     (rst_sel)
  );

  mode_next u_next (
    .cur        (mode_q),
    .wr_val     (wr_val),
    .wr_en      (csr_we),
    .enter      (exc_enter),
    .merr_enter (merr_enter),
    .ret        (exc_return),
    .rst_sel    (rst_sel),
    .nxt        (mode_d),
    .load       (load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= RST_VAL;
    else if (load) mode_q <= mode_d;
  end

  if (XLEN > MODE_W) begin : g_pad
    assign csr_rdata = {{(XLEN-MODE_W){1'b0}}, mode_q};
  end else begin : g_nopad
    assign csr_rdata = mode_q[XLEN-1:0];
  end

  assign priv_lvl    = mode_q.priv;
  assign int_en      = mode_q.ie;
  assign direct_xlat = mode_q.direct;
  assign paged_xlat  = mode_q.paged;
  assign fetch_mat   = mode_q.fmat;
  assign data_mat    = mode_q.dmat;
  assign wpt_en      = mode_q.wpt;

  // R4
  entry_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_enter || merr_enter) |=> (priv_lvl == 2'd0 && !wpt_en &&
      int_en == $past(int_en) && direct_xlat == $past(direct_xlat) &&
      paged_xlat == $past(paged_xlat)));

  // R5
  merr_mat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merr_enter |=> (fetch_mat == 2'b00 && data_mat == 2'b00));

  // R6
  ret_merr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_enter && !merr_enter && merr_flag) |=>
      (priv_lvl == $past(merr_ctx_priv) && wpt_en == $past(merr_ctx_wpt) &&
       fetch_mat == $past(merr_ctx_fmat) && data_mat == $past(merr_ctx_dmat)));

  // R7
  ret_refill_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_enter && !merr_enter && !merr_flag && refill_flag) |=>
      (priv_lvl == $past(refill_ctx_priv) && wpt_en == $past(refill_ctx_wpt) &&
       fetch_mat == $past(fetch_mat) && data_mat == $past(data_mat)));

  // R8
  ret_norm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_enter && !merr_enter && !merr_flag && !refill_flag) |=>
      (priv_lvl == $past(norm_ctx_priv) && wpt_en == $past(norm_ctx_wpt)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_we && !exc_enter && !merr_enter && !exc_return) |=> $stable(csr_rdata));
endmodule

// File: tb/tb_mode_ctrl_reg.sv
`timescale 1ns/1ps
module tb_mode_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 0, exc_enter = 0, merr_enter = 0, exc_return = 0;
  logic [31:0] csr_wmask = 0, csr_wdata = 0;
  logic        merr_flag = 0, merr_ctx_wpt = 0, refill_flag = 0, refill_ctx_wpt = 0, norm_ctx_wpt = 0;
  logic [1:0]  merr_ctx_priv = 0, merr_ctx_fmat = 0, merr_ctx_dmat = 0, refill_ctx_priv = 0, norm_ctx_priv = 0;
  logic [31:0] csr_rdata;
  logic [1:0]  priv_lvl, fetch_mat, data_mat;
  logic        int_en, direct_xlat, paged_xlat, wpt_en;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [9:0] model;

  always #4 clk = ~clk;

  mode_ctrl_reg dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Layout: [9]=wpt [8:7]=dmat [6:5]=fmat [4]=paged [3]=direct [2]=ie [1:0]=priv
  function automatic logic [9:0] step_model(logic [9:0] m);
    logic [9:0] n = m;
    if (exc_enter || merr_enter) begin
      n[1:0] = 0; n[9] = 0;
      if (merr_enter) n[8:5] = 0;
    end else if (exc_return) begin
      if (merr_flag) begin
        n[1:0] = merr_ctx_priv; n[9] = merr_ctx_wpt;
        n[6:5] = merr_ctx_fmat; n[8:7] = merr_ctx_dmat;
      end else if (refill_flag) begin
        n[1:0] = refill_ctx_priv; n[9] = refill_ctx_wpt;
      end else begin
        n[1:0] = norm_ctx_priv; n[9] = norm_ctx_wpt;
      end
    end else if (csr_we) begin
      n = (m & ~csr_wmask[9:0]) | (csr_wdata[9:0] & csr_wmask[9:0]);
    end
    return n;
  endfunction

  function automatic string tag_of();
    if (exc_enter && !merr_enter && csr_we) return "R9/R4";
    if (merr_enter && csr_we) return "R9/R5";
    if (exc_return && csr_we) return "R9";
    if (merr_enter) return "R5";
    if (exc_enter) return "R4";
    if (exc_return && merr_flag) return "R6";
    if (exc_return && refill_flag) return "R7";
    if (exc_return) return "R8";
    if (csr_we) return "R3";
    return "R10";
  endfunction

  task automatic compare_all(string req);
    check(req, csr_rdata, {22'd0, model});
    // R2 decoded outputs and zero upper bits
    check("R2", {22'd0, wpt_en, data_mat, fetch_mat, paged_xlat, direct_xlat, int_en, priv_lvl},
          csr_rdata);
  endtask

  task automatic cycle();
    string req;
    req = tag_of();
    model = step_model(model);
    @(posedge clk); #1;
    compare_all(req);
    @(negedge clk);
  endtask

  task automatic clear_in();
    csr_we = 0; exc_enter = 0; merr_enter = 0; exc_return = 0;
  endtask

  task automatic rand_ctx();
    csr_wmask = $urandom; csr_wdata = $urandom;
    merr_ctx_priv = 2'($urandom); merr_ctx_wpt = 1'($urandom);
    merr_ctx_fmat = 2'($urandom); merr_ctx_dmat = 2'($urandom);
    refill_ctx_priv = 2'($urandom); refill_ctx_wpt = 1'($urandom);
    norm_ctx_priv = 2'($urandom); norm_ctx_wpt = 1'($urandom);
    merr_flag = 1'($urandom); refill_flag = 1'($urandom);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", csr_rdata, 32'h0000_0008);
    check("R1", {30'd0, priv_lvl}, 32'd0);
    rst_n = 1'b1;
    model = 10'h008;
    @(negedge clk);

    // R3 single-field write: set paged, fetch/data CC, upper mask bits ignored
    csr_we = 1; csr_wmask = 32'hFFFF_F9F0; csr_wdata = 32'hFFFF_FCB0;
    cycle(); clear_in();
    // R10 idle with garbage inputs
    rand_ctx(); cycle();
    // R3 set privilege 3, ie, watchpoints
    csr_we = 1; csr_wmask = 32'h207; csr_wdata = 32'h207; cycle(); clear_in();
    // R5 machine-error entry clears mats
    merr_enter = 1; cycle(); clear_in();
    // R6 return from machine error, priority over refill
    merr_flag = 1; refill_flag = 1; merr_ctx_priv = 2; merr_ctx_wpt = 1;
    merr_ctx_fmat = 1; merr_ctx_dmat = 2; exc_return = 1; cycle(); clear_in();
    // R4 entry with colliding write (R9)
    csr_we = 1; csr_wmask = 32'h3FF; csr_wdata = 32'h3FF; exc_enter = 1; cycle(); clear_in();
    // R7 refill return keeps mats
    merr_flag = 0; refill_flag = 1; refill_ctx_priv = 3; refill_ctx_wpt = 1;
    exc_return = 1; cycle(); clear_in();
    // R8 ordinary return with colliding write (R9)
    refill_flag = 0; norm_ctx_priv = 1; norm_ctx_wpt = 0; csr_we = 1;
    csr_wmask = 32'h3FF; csr_wdata = 32'h0; exc_return = 1; cycle(); clear_in();
    // R9 entry wins over return
    exc_enter = 1; exc_return = 1; cycle(); clear_in();

    for (int i = 0; i < 600; i++) begin
      int k;
      rand_ctx(); clear_in();
      k = $urandom_range(0, 9);
      case (k)
        0, 1, 2: csr_we = 1;
        3: exc_enter = 1;
        4: merr_enter = 1;
        5, 6: exc_return = 1;
        7: begin csr_we = 1; exc_enter = 1; end
        8: begin csr_we = 1; exc_return = 1; end
        default: ;
      endcase
      cycle();
    end
    clear_in();

    // R1 reset mid-run
    rst_n = 0; #1;
    check("R1", csr_rdata, 32'h0000_0008);
    model = 10'h008;
    @(negedge clk); rst_n = 1; @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule